// File: doc/BRIEF.md
# Dual DAC Serial Latch Controller

This block is the digital control core of a two-channel 10-bit voltage DAC. A host writes 16-bit command words over a three-wire serial port made of an active-low chip select, a serial clock and a data line. The top four bits of each word are program bits. They steer the 10-bit code into channel A's latch, channel B's latch and a shared staging latch, and they set a settling-speed flag and a power-down flag. The two latch values and the two flags drive the analog converter next to the block.

All three serial lines are synchronised into one system clock domain and edge-detected there. Data is sampled on each falling serial-clock edge. The staging latch lets the host preload channel B and then update both channels together with a single channel-A write. The parameter `AUTO_TERM` picks the framing. With `AUTO_TERM = 0`, a frame ends only when chip select rises. With `AUTO_TERM = 1`, the frame ends by itself on the sixteenth falling clock edge, and an earlier chip-select rise also ends it.

Top module: `dual_dac_ctrl`

## Requirements
- R1: After reset, both channel codes, the staging latch, the speed flag and the power-down flag are all zero.
- R2: While chip select is low, each falling serial-clock edge shifts the data line into a 16-bit register, most significant bit first. Bits 11 down to 2 of the word form the code, with its MSB at bit 11. Bits 1 and 0 have no effect on any output.
- R3: With AUTO_TERM = 0, no output changes while chip select stays low. The outputs update once chip select rises, using the word then held in the register.
- R4: A word with bit 15 = 1 loads the code into channel A and copies the staging latch into channel B in the same transfer. The staging latch keeps its value.
- R5: A word with bit 15 = 0 and bit 12 = 0 loads the code into both channel B and the staging latch. Channel A keeps its value.
- R6: A word with bit 15 = 0 and bit 12 = 1 loads the code into the staging latch only. Both channel outputs keep their values.
- R7: Every transfer copies bit 14 into the speed flag (1 = slow) and bit 13 into the power-down flag (1 = powered down), whichever latches the word selects.
- R8: With AUTO_TERM = 0, a frame with more than 16 clock edges transfers the last 16 bits shifted in.
- R9: With AUTO_TERM = 1, the sixteenth falling edge after chip select falls triggers the transfer while chip select is still low. Further clock edges are ignored until chip select falls again.
- R10: With AUTO_TERM = 1, a chip-select rise before the sixteenth edge ends the frame and transfers the current register contents.
- R11: With AUTO_TERM = 1, each frame makes at most one transfer. A chip-select rise after a completed sixteen-edge transfer changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Serial chip select, active low |
| sck_i | input | 1 | Serial clock; data sampled on falling edges |
| sdi_i | input | 1 | Serial data, MSB first |
| code_a_o | output | 10 | Channel A code |
| code_b_o | output | 10 | Channel B code |
| slow_o | output | 1 | Settling speed select, 1 = slow |
| pwrdn_o | output | 1 | Power-down request, 1 = powered down |

## Verification
The assertions assume the serial lines are slow compared with the system clock. They also assume chip select moves only while the serial clock is low, so a chip-select edge and a clock edge never reach the synchronised domain in the same cycle. The bench holds each serial level for four system clocks, changes data only while the clock is low, and brackets every frame with idle gaps. This keeps every transfer a clean single-cycle event whose word has already settled. Each framing mode is driven on its own instance with its own chip select, so frames sent to one instance leave the other instance's outputs unchanged.

// File: rtl/dac_ctrl_pkg.sv
package dac_ctrl_pkg;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned CODE_W   = 10;
  localparam int unsigned CODE_LSB = 2;
  // program bit positions decoded by the latch bank
  localparam int unsigned POS_TO_A = 15;
  localparam int unsigned POS_SLOW = 14;
  localparam int unsigned POS_PD   = 13;
  localparam int unsigned POS_STG  = 12;

  typedef enum logic [1:0] {
    XF_LOAD_A   = 2'd0,
    XF_LOAD_B   = 2'd1,
    XF_STG_ONLY = 2'd2
  } xfer_kind_e;

  typedef struct packed {
    xfer_kind_e        kind;
    logic              slow;
    logic              pwrdn;
    logic [CODE_W-1:0] code;
  } cmd_t;

  function automatic cmd_t decode_word(input logic [WORD_W-1:0] w);
    cmd_t c;
    c.code  = w[CODE_LSB +: CODE_W];
    c.slow  = w[POS_SLOW];
    c.pwrdn = w[POS_PD];
    if (w[POS_TO_A])     c.kind = XF_LOAD_A;
    else if (w[POS_STG]) c.kind = XF_STG_ONLY;
    else                 c.kind = XF_LOAD_B;
    return c;
  endfunction
endpackage

// File: rtl/serial_sync.sv
module serial_sync #(
  parameter int unsigned            STAGES  = 2,
  parameter int unsigned            WIDTH   = 3,
  parameter logic [WIDTH-1:0]       RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  // one extra stage holds the previous synchronised value
  logic [STAGES:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= {(STAGES+1){RST_VAL}};
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i <= STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];
  assign rise_o = stg_q[STAGES-1] & ~stg_q[STAGES];
  assign fall_o = ~stg_q[STAGES-1] & stg_q[STAGES];
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
  import dac_ctrl_pkg::*;
#(
  parameter bit AUTO_TERM = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_fall_i,
  input  logic              sel_rise_i,
  input  logic              sck_fall_i,
  input  logic              sdi_i,
  output logic [WORD_W-1:0] word_o,
  output logic              xfer_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WORD_W - 1);

  logic              open_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] sh_q;
  logic              xfer_q;
  logic              shift_en;
  logic              last_edge;
  logic              xfer_d;

  assign shift_en = sck_fall_i & open_q;

  generate
    if (AUTO_TERM) begin : g_auto
      assign last_edge = shift_en & (cnt_q == LAST_CNT);
      // internal end-of-frame ORed with an early select rise
      assign xfer_d    = last_edge | (sel_rise_i & open_q);
    end else begin : g_plain
      assign last_edge = 1'b0;
      assign xfer_d    = sel_rise_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else if (sel_fall_i) begin
      open_q <= 1'b1;
      cnt_q  <= '0;
    end else if (sel_rise_i || last_edge) begin
      open_q <= 1'b0;
    end else if (shift_en && cnt_q != LAST_CNT) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sh_q <= '0;
    else if (shift_en) sh_q <= {sh_q[WORD_W-2:0], sdi_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) xfer_q <= 1'b0;
    else         xfer_q <= xfer_d;
  end

  assign word_o = sh_q;
  assign xfer_o = xfer_q;
endmodule

// File: rtl/latch_bank.sv
module latch_bank
  import dac_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xfer_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [CODE_W-1:0] code_a_o,
  output logic [CODE_W-1:0] code_b_o,
  output logic              slow_o,
  output logic              pwrdn_o
);
  cmd_t              cmd;
  logic [CODE_W-1:0] a_q, b_q, stg_q;
  logic              slow_q, pd_q;

  assign cmd = decode_word(word_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q    <= '0;
      b_q    <= '0;
      stg_q  <= '0;
      slow_q <= 1'b0;
      pd_q   <= 1'b0;
    end else if (xfer_i) begin
      slow_q <= cmd.slow;
      pd_q   <= cmd.pwrdn;
      unique case (cmd.kind)
        XF_LOAD_A: begin
          a_q <= cmd.code;
          b_q <= stg_q;
        end
        XF_LOAD_B: begin
          b_q   <= cmd.code;
          stg_q <= cmd.code;
        end
        XF_STG_ONLY: stg_q <= cmd.code;
        default: ;
      endcase
    end
  end

  assign code_a_o = a_q;
  assign code_b_o = b_q;
  assign slow_o   = slow_q;
  assign pwrdn_o  = pd_q;
endmodule

// File: rtl/dual_dac_ctrl.sv
module dual_dac_ctrl
  import dac_ctrl_pkg::*;
#(
  parameter bit          AUTO_TERM   = 1'b0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              sdi_i,
  output logic [CODE_W-1:0] code_a_o,
  output logic [CODE_W-1:0] code_b_o,
  output logic              slow_o,
  output logic              pwrdn_o
);
  localparam int unsigned PIN_N = 3;
  localparam int unsigned IX_CS = 2;
  localparam int unsigned IX_CK = 1;
  localparam int unsigned IX_DI = 0;

  logic [PIN_N-1:0]  pin_sync, pin_rise, pin_fall;
  logic              sel_fall, sel_rise, sck_fall;
  logic [WORD_W-1:0] shreg;
  logic              xfer;

  // select idles high so reset never looks like a frame start
  serial_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (PIN_N),
    .RST_VAL(PIN_N'(1) << IX_CS)
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sck_i, sdi_i}),
    .sync_o(pin_sync),
    .rise_o(pin_rise),
    .fall_o(pin_fall)
  );

  assign sel_fall = pin_fall[IX_CS];
  assign sel_rise = pin_rise[IX_CS];
  assign sck_fall = pin_fall[IX_CK];

  frame_shifter #(.AUTO_TERM(AUTO_TERM)) i_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_fall_i(sel_fall),
    .sel_rise_i(sel_rise),
    .sck_fall_i(sck_fall),
    .sdi_i     (pin_sync[IX_DI]),
    .word_o    (shreg),
    .xfer_o    (xfer)
  );

  latch_bank i_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .xfer_i  (xfer),
    .word_i  (shreg),
    .code_a_o(code_a_o),
    .code_b_o(code_b_o),
    .slow_o  (slow_o),
    .pwrdn_o (pwrdn_o)
  );

  logic unused_pins;
  assign unused_pins = ^{pin_sync[IX_CS], pin_sync[IX_CK], pin_rise[IX_CK],
                         pin_rise[IX_DI], pin_fall[IX_DI]};
endmodule

// File: rtl/dual_dac_ctrl_chk.sv
module dual_dac_ctrl_chk
  import dac_ctrl_pkg::*;
#(
  parameter bit AUTO_TERM = 1'b0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              xfer_i,
  input logic              sel_fall_i,
  input logic [WORD_W-1:0] word_i,
  input logic [CODE_W-1:0] code_a_o,
  input logic [CODE_W-1:0] code_b_o,
  input logic              slow_o,
  input logic              pwrdn_o
);
  logic [1:0] xf_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       xf_cnt_q <= '0;
    else if (sel_fall_i)               xf_cnt_q <= '0;
    else if (xfer_i && xf_cnt_q != 2'd3) xf_cnt_q <= xf_cnt_q + 2'd1;
  end

  // R3
  hold_outputs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_i |=> ($stable(code_a_o) && $stable(code_b_o) && $stable(slow_o) && $stable(pwrdn_o)));

  // R4
  load_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i && word_i[POS_TO_A]) |=> code_a_o == $past(word_i[CODE_LSB +: CODE_W]));

  // R5
  load_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i && !word_i[POS_TO_A] && !word_i[POS_STG])
      |=> (code_b_o == $past(word_i[CODE_LSB +: CODE_W]) && $stable(code_a_o)));

  // R6
  stage_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i && !word_i[POS_TO_A] && word_i[POS_STG])
      |=> ($stable(code_a_o) && $stable(code_b_o)));

  // R7
  flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_i |=> (slow_o == $past(word_i[POS_SLOW]) && pwrdn_o == $past(word_i[POS_PD])));

  // R11
  one_xfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (AUTO_TERM == 1'b0) || (xf_cnt_q < 2'd2));
endmodule

bind dual_dac_ctrl dual_dac_ctrl_chk #(.AUTO_TERM(AUTO_TERM)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .xfer_i    (xfer),
  .sel_fall_i(sel_fall),
  .word_i    (shreg),
  .code_a_o  (code_a_o),
  .code_b_o  (code_b_o),
  .slow_o    (slow_o),
  .pwrdn_o   (pwrdn_o)
);

// File: tb/test_dual_dac_ctrl.sv
module test_dual_dac_ctrl;
  localparam time CLK_PERIOD = 10ns;
  localparam int  HOLD       = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_plain_n = 1'b1, cs_auto_n = 1'b1;
  logic sck = 1'b0, sdi = 1'b0;
  logic [9:0] pa, pb, aa, ab;
  logic ps, pp, as_, ap;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // index 0 = plain framing instance, 1 = auto-terminate instance
  logic [15:0] m_sh [2];
  logic [9:0]  m_a [2], m_b [2], m_db [2];
  logic        m_slow [2], m_pd [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_dac_ctrl #(.AUTO_TERM(1'b0)) i_dual_dac_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_plain_n), .sck_i(sck), .sdi_i(sdi),
    .code_a_o(pa), .code_b_o(pb), .slow_o(ps), .pwrdn_o(pp));

  dual_dac_ctrl #(.AUTO_TERM(1'b1)) i_dual_dac_ctrl_auto (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_auto_n), .sck_i(sck), .sdi_i(sdi),
    .code_a_o(aa), .code_b_o(ab), .slow_o(as_), .pwrdn_o(ap));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_inst(input int idx, input string tag);
    if (idx == 0) begin
      chk({tag, " code_a"}, 32'(pa), 32'(m_a[0]));
      chk({tag, " code_b"}, 32'(pb), 32'(m_b[0]));
      chk({tag, " flags"},  32'({ps, pp}), 32'({m_slow[0], m_pd[0]}));
    end else begin
      chk({tag, " code_a"}, 32'(aa), 32'(m_a[1]));
      chk({tag, " code_b"}, 32'(ab), 32'(m_b[1]));
      chk({tag, " flags"},  32'({as_, ap}), 32'({m_slow[1], m_pd[1]}));
    end
  endtask

  function automatic void apply(input int idx);
    logic [15:0] w = m_sh[idx];
    logic [9:0]  c = w[11:2];
    if (w[15]) begin
      m_a[idx] = c;
      m_b[idx] = m_db[idx];
    end else if (!w[12]) begin
      m_b[idx]  = c;
      m_db[idx] = c;
    end else begin
      m_db[idx] = c;
    end
    m_slow[idx] = w[14];
    m_pd[idx]   = w[13];
  endfunction

  // sends n bits of 'bits' MSB first; idx selects the instance
  task automatic frame(input int idx, input logic [31:0] bits, input int n, input string tag);
    int taken = 0;
    if (idx == 0) cs_plain_n = 1'b0; else cs_auto_n = 1'b0;
    repeat (HOLD) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = bits[i];
      repeat (HOLD) @(negedge clk);
      sck = 1'b1;
      repeat (HOLD) @(negedge clk);
      sck = 1'b0;
      if (idx == 0 || taken < 16) begin
        m_sh[idx] = {m_sh[idx][14:0], bits[i]};
        taken++;
        if (idx == 1 && taken == 16) begin
          apply(1);
          repeat (2 * HOLD) @(negedge clk);
          check_inst(1, {tag, " R9 transfer with select low"});
          continue;
        end
      end
      repeat (HOLD) @(negedge clk);
      // R3: plain instance holds its outputs mid-frame
      if (idx == 0 && i == 8) check_inst(0, {tag, " R3 mid-frame"});
    end
    repeat (HOLD) @(negedge clk);
    if (idx == 0) cs_plain_n = 1'b1; else cs_auto_n = 1'b1;
    if (idx == 0 || taken < 16) apply(idx);
    repeat (3 * HOLD) @(negedge clk);
    check_inst(idx, tag);
    check_inst(1 - idx, {tag, " other instance untouched"});
  endtask

  task automatic t_reset();
    check_inst(0, "R1 reset");
    check_inst(1, "R1 reset");
  endtask

  task automatic t_load_b();
    // b15=0 fast, up, b12=0, code 0x155, fill 11 (R2 fill ignored)
    frame(0, 32'({4'b0000, 10'h155, 2'b11}), 16, "R5 load B");
    frame(0, 32'({4'b0000, 10'h155, 2'b00}), 16, "R2 fill bits ignored");
  endtask

  task automatic t_load_a();
    frame(0, 32'({4'b1000, 10'h2AA, 2'b01}), 16, "R4 load A copies staging");
  endtask

  task automatic t_staging();
    frame(0, 32'({4'b0001, 10'h3FF, 2'b00}), 16, "R6 staging only");
    frame(0, 32'({4'b1000, 10'h200, 2'b10}), 16, "R4 simultaneous update");
    frame(0, 32'({4'b1000, 10'h001, 2'b00}), 16, "R4 repeat A keeps B");
  endtask

  task automatic t_flags();
    frame(0, 32'({4'b0111, 10'h0F0, 2'b00}), 16, "R7 slow and power-down");
    frame(0, 32'({4'b1000, 10'h0F1, 2'b00}), 16, "R7 flags cleared");
  endtask

  task automatic t_plain_long();
    frame(0, {14'h0, 2'b11, 4'b0000, 10'h0AB, 2'b00}, 18, "R8 last sixteen bits");
  endtask

  task automatic t_auto_full();
    // extra four edges carry ones that must not land
    frame(1, {12'h0, 4'b0001, 10'h123, 2'b00, 4'hF}, 20, "R11 no second transfer");
    frame(1, {12'h0, 4'b1100, 10'h321, 2'b00, 4'hA}, 20, "R9 extra edges ignored");
  endtask

  task automatic t_auto_early();
    frame(1, 32'({4'b0000, 4'hC}), 8, "R10 early select rise");
  endtask

  initial begin
    for (int k = 0; k < 2; k++) begin
      m_sh[k] = '0; m_a[k] = '0; m_b[k] = '0; m_db[k] = '0;
      m_slow[k] = 1'b0; m_pd[k] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_load_b();
    t_load_a();
    t_staging();
    t_flags();
    t_plain_long();
    t_auto_full();
    t_auto_early();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule